// File: doc/BRIEF.md
# Cumulative Clock-Stretch Timeout Monitor

This block watches the sampled level of the serial clock line and adds up how long it is held low during one bus transaction. It applies the same measure to a slave that stretches the clock over a whole message and to a master that stretches it within each byte. Low time is counted in units of 2048 kernel clocks. When the total passes a programmable limit, a sticky timeout status flag is raised.

The protocol engine supplies one-cycle strobes for START and STOP conditions. Each strobe discards the time counted so far. Software programs a 12-bit threshold while the monitor is off and then sets the enable input. From that point the threshold is frozen. The flag stays set until software pulses the clear input. A single interrupt request output is the flag gated by an interrupt enable.

Top module: `stretch_tmo_mon`

## Requirements
- R1: While `mon_en` is 0, a cycle with `thr_we` high loads `thr_wdata` into the 12-bit threshold register. The register reads back on `thr_value` from the next cycle. After reset it holds 0.
- R2: While `mon_en` is 1, `thr_we` has no effect on `thr_value`.
- R3: With threshold T, `tmo_flag` rises on the clock edge that completes the (T+1)×2048-th counted low cycle, and not one cycle earlier.
- R4: A cycle is counted when, at the clock edge, `mon_en` is 1, `scl_in` is 0 and neither event strobe is high. Cycles with SCL high pause the count and do not clear it, so separate low stretches add up.
- R5: A cycle with `start_evt` or `stop_evt` high clears the accumulated low time, including the partial 2048-cycle unit.
- R6: A cycle with `mon_en` low clears the accumulated low time.
- R7: Once set, `tmo_flag` stays at 1 while SCL is high or the bus goes idle. It stays until a cycle with `tmo_clr` high, after which it reads 0.
- R8: `tmo_flag` never goes from 0 to 1 on an edge where `mon_en` was 0, whatever SCL does.
- R9: `irq_req` is 1 exactly when `tmo_flag` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL level |
| start_evt | input | 1 | One-cycle START condition strobe |
| stop_evt | input | 1 | One-cycle STOP condition strobe |
| mon_en | input | 1 | Monitor enable; locks the threshold |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 12 | Threshold write value |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt request enable |
| thr_value | output | 12 | Current threshold |
| tmo_flag | output | 1 | Sticky timeout status |
| irq_req | output | 1 | Interrupt request |

## Verification
Three kinds of input pattern are used.

- One unbroken low stretch, stopped one cycle before and then exactly at the limit. This separates a correct compare from an off-by-one in the prescaler or the accumulator.
- Low stretches split by high gaps. These show whether time accumulates across a transaction or only one continuous period is measured.
- Low time cut by a START, a STOP or an enable drop, followed by a full limit. This shows whether the partial prescaler count is really discarded.

Random segment sequences with random thresholds, gaps and event strobes are compared with a cycle-counting model. A long low period with the monitor disabled confirms the flag never sets.

// File: rtl/stm_pkg.sv
package stm_pkg;

    // Per-cycle decision taken from bus state and enable
    typedef struct packed {
        logic run;    // count this cycle as stretched low time
        logic clear;  // discard accumulated time
    } stm_step_t;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_e;

    function automatic stm_step_t decode_step(
        input logic en,
        input logic scl,
        input logic start_ev,
        input logic stop_ev
    );
        stm_step_t s;
        s.clear = !en || start_ev || stop_ev;
        s.run   = !s.clear && !scl;
        return s;
    endfunction

    // Set has priority so a timeout in the clearing cycle is not lost
    function automatic flag_act_e flag_action(input logic hit, input logic clr);
        if (hit)      return FLAG_SET;
        else if (clr) return FLAG_CLEAR;
        else          return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/stm_thr_reg.sv
module stm_thr_reg #(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic             we,
    input  logic [THR_W-1:0] wdata,
    output logic [THR_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (we && !locked)
            value <= wdata;
    end
endmodule

// File: rtl/stm_prescaler.sv
module stm_prescaler
    import stm_pkg::*;
#(
    parameter int PRESC = 2048
) (
    input  logic      clk,
    input  logic      rst,
    input  stm_step_t step,
    output logic      tick
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] cnt_q;

    assign tick = step.run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || step.clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else if (step.run)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/stm_accum.sv
module stm_accum
    import stm_pkg::*;
#(
    parameter int THR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  stm_step_t        step,
    input  logic             tick,
    input  logic [THR_W-1:0] thr,
    output logic [THR_W-1:0] acc,
    output logic             hit
);
    localparam logic [THR_W-1:0] ACC_MAX = '1;

    // The tick that would push the count past thr is the crossing point
    assign hit = tick && (acc == thr);

    always_ff @(posedge clk) begin
        if (rst || step.clear)
            acc <= '0;
        else if (tick && acc != ACC_MAX)
            acc <= acc + 1'b1;
    end
endmodule

// File: rtl/stretch_tmo_mon.sv
module stretch_tmo_mon
    import stm_pkg::*;
#(
    parameter int THR_W = 12,
    parameter int PRESC = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             mon_en,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             tmo_clr,
    input  logic             irq_en,
    output logic [THR_W-1:0] thr_value,
    output logic             tmo_flag,
    output logic             irq_req
);
    stm_step_t        step;
    logic             tick;
    logic             hit;
    logic [THR_W-1:0] acc_cnt;
    flag_act_e        act;

    assign step = decode_step(mon_en, scl_in, start_evt, stop_evt);

    stm_thr_reg #(.THR_W(THR_W)) u_thr (
        .clk    (clk),
        .rst    (rst),
        .locked (mon_en),
        .we     (thr_we),
        .wdata  (thr_wdata),
        .value  (thr_value)
    );

    stm_prescaler #(.PRESC(PRESC)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .tick (tick)
    );

    stm_accum #(.THR_W(THR_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .tick (tick),
        .thr  (thr_value),
        .acc  (acc_cnt),
        .hit  (hit)
    );

    assign act = flag_action(hit, tmo_clr);

    always_ff @(posedge clk) begin
        if (rst)
            tmo_flag <= 1'b0;
        else begin
            case (act)
                FLAG_SET:   tmo_flag <= 1'b1;
                FLAG_CLEAR: tmo_flag <= 1'b0;
                default:    tmo_flag <= tmo_flag;
            endcase
        end
    end

    assign irq_req = tmo_flag && irq_en;
endmodule

// File: rtl/stretch_tmo_mon_chk.sv
module stretch_tmo_mon_chk #(
    parameter int THR_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_in,
    input logic             start_evt,
    input logic             stop_evt,
    input logic             mon_en,
    input logic             thr_we,
    input logic             tmo_clr,
    input logic             irq_en,
    input logic [THR_W-1:0] thr_value,
    input logic [THR_W-1:0] acc_cnt,
    input logic             tmo_flag,
    input logic             irq_req
);
    // R2: a write under enable leaves the threshold untouched
    a_r2_thr_locked: assert property (@(posedge clk) disable iff (rst)
        (mon_en && thr_we) |=> $stable(thr_value));

    // R4: SCL high with nothing else happening keeps the accumulated count
    a_r4_pause_keeps: assert property (@(posedge clk) disable iff (rst)
        (mon_en && scl_in && !start_evt && !stop_evt) |=> $stable(acc_cnt));

    // R5: bus events wipe the accumulated count
    a_r5_event_clears: assert property (@(posedge clk) disable iff (rst)
        (start_evt || stop_evt) |=> (acc_cnt == '0));

    // R6: disabling wipes the accumulated count
    a_r6_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !mon_en |=> (acc_cnt == '0));

    // R7: flag holds without a clear
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !tmo_clr) |=> tmo_flag);

    // R8: no rising flag from a disabled cycle
    a_r8_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && !tmo_flag) |=> !tmo_flag);

    // R9: request tracks flag and enable
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (tmo_flag && irq_en));
endmodule

bind stretch_tmo_mon stretch_tmo_mon_chk #(.THR_W(THR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .mon_en    (mon_en),
    .thr_we    (thr_we),
    .tmo_clr   (tmo_clr),
    .irq_en    (irq_en),
    .thr_value (thr_value),
    .acc_cnt   (acc_cnt),
    .tmo_flag  (tmo_flag),
    .irq_req   (irq_req)
);

// File: tb/stretch_tmo_mon_tb.sv
module stretch_tmo_mon_tb_top;
    localparam int THR_W = 12;
    localparam int UNIT  = 2048;

    logic             clk = 1'b0;
    logic             rst;
    logic             scl_in, start_evt, stop_evt, mon_en, thr_we, tmo_clr, irq_en;
    logic [THR_W-1:0] thr_wdata;
    logic [THR_W-1:0] thr_value;
    logic             tmo_flag, irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    int  m_low  = 0;
    int  m_thr  = 0;
    bit  m_flag = 0;

    always #5 clk = ~clk;

    stretch_tmo_mon dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .start_evt(start_evt),
        .stop_evt(stop_evt), .mon_en(mon_en), .thr_we(thr_we),
        .thr_wdata(thr_wdata), .tmo_clr(tmo_clr), .irq_en(irq_en),
        .thr_value(thr_value), .tmo_flag(tmo_flag), .irq_req(irq_req)
    );

    function automatic int limit_of(input int thr);
        return (thr + 1) * UNIT;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock with inputs held; model updated after the edge
    task automatic cyc(input logic scl, input logic st, input logic sp);
        scl_in = scl; start_evt = st; stop_evt = sp;
        @(posedge clk); #2;
        if (!mon_en || st || sp) m_low = 0;
        else if (!scl) begin
            m_low++;
            if (m_low == limit_of(m_thr)) m_flag = 1;
        end
        if (tmo_clr && !(mon_en && !scl && !st && !sp && m_low == limit_of(m_thr)))
            m_flag = 0;
        start_evt = 0; stop_evt = 0;
    endtask

    task automatic run(input int n, input logic scl);
        for (int i = 0; i < n; i++) cyc(scl, 1'b0, 1'b0);
    endtask

    task automatic set_thr(input int v);
        mon_en = 0; thr_we = 1; thr_wdata = THR_W'(v);
        cyc(1'b1, 1'b0, 1'b0);
        thr_we = 0;
        m_thr = v;
    endtask

    task automatic clear_flag();
        tmo_clr = 1; cyc(1'b1, 1'b0, 1'b0); tmo_clr = 0;
    endtask

    initial begin
        rst = 1; scl_in = 1; start_evt = 0; stop_evt = 0; mon_en = 0;
        thr_we = 0; thr_wdata = '0; tmo_clr = 0; irq_en = 0;
        repeat (3) @(posedge clk);
        #2; rst = 0;
        chk("R1 reset threshold", int'(thr_value), 0);
        chk("R7 reset flag", int'(tmo_flag), 0);
        chk("R9 reset irq", int'(irq_req), 0);

        // R1: write while disabled
        set_thr(5);
        chk("R1 threshold write", int'(thr_value), 5);

        // R2: write while enabled is ignored
        mon_en = 1; cyc(1'b1, 1'b0, 1'b0);
        thr_we = 1; thr_wdata = 12'd9; cyc(1'b1, 1'b0, 1'b0); thr_we = 0;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R2 locked threshold", int'(thr_value), 5);

        // R3: exact boundary with threshold 1
        set_thr(1); mon_en = 1;
        run(limit_of(1) - 1, 1'b0);
        chk("R3 one before limit", int'(tmo_flag), 0);
        run(1, 1'b0);
        chk("R3 at limit", int'(tmo_flag), 1);
        chk("R9 irq masked", int'(irq_req), 0);
        irq_en = 1; #1;
        chk("R9 irq raised", int'(irq_req), 1);

        // R7: bus recovers, flag holds, then clears
        run(50, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        chk("R7 flag holds", int'(tmo_flag), 1);
        clear_flag();
        chk("R7 flag cleared", int'(tmo_flag), 0);
        chk("R9 irq follows", int'(irq_req), 0);

        // R4: cumulative across high gaps, threshold 0
        set_thr(0); mon_en = 1;
        run(1000, 1'b0); run(300, 1'b1); run(1047, 1'b0);
        chk("R4 split short", int'(tmo_flag), 0);
        run(1, 1'b0);
        chk("R4 split total", int'(tmo_flag), 1);
        clear_flag();

        // R5: START discards partial time
        run(2000, 1'b0); cyc(1'b0, 1'b1, 1'b0);
        run(UNIT - 1, 1'b0);
        chk("R5 after start short", int'(tmo_flag), 0);
        run(1, 1'b0);
        chk("R5 after start limit", int'(tmo_flag), 1);
        clear_flag();

        // R5: STOP discards partial time
        run(2000, 1'b0); cyc(1'b0, 1'b0, 1'b1);
        run(UNIT - 1, 1'b0);
        chk("R5 after stop short", int'(tmo_flag), 0);
        run(1, 1'b0);
        chk("R5 after stop limit", int'(tmo_flag), 1);
        clear_flag();

        // R6: enable drop discards partial time
        run(2000, 1'b0); mon_en = 0; cyc(1'b0, 1'b0, 1'b0); mon_en = 1;
        run(UNIT - 1, 1'b0);
        chk("R6 after disable short", int'(tmo_flag), 0);
        run(1, 1'b0);
        chk("R6 after disable limit", int'(tmo_flag), 1);
        clear_flag();

        // R8: disabled monitor never flags
        mon_en = 0; run(3 * UNIT, 1'b0);
        chk("R8 disabled long low", int'(tmo_flag), 0);

        // Random segments against the model (R3 R4 R5)
        void'($urandom(32'h5eed_1234));
        for (int it = 0; it < 8; it++) begin
            set_thr(int'($urandom_range(0, 2)));
            mon_en = 1; clear_flag();
            for (int s = 0; s < 16; s++) begin
                int len;
                len = int'($urandom_range(1, 900));
                case ($urandom_range(0, 5))
                    0: cyc(1'b0, 1'b1, 1'b0);
                    1: cyc(1'b1, 1'b0, 1'b1);
                    2, 3: run(len, 1'b0);
                    default: run(len, 1'b1);
                endcase
                chk("R4 random model", int'(tmo_flag), int'(m_flag));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule